// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets a host controller read and write a bank of 8-bit configuration registers over a slow serial port. The port has five wires: a serial clock, a data line that carries both directions, a strobe, a read/write select and an active-low chip select. The serial clock has no fixed phase relation to the block's master clock. The block samples every serial input in the master clock domain and finds the serial clock edges there. The data line is split into an input, an output and an output enable, and the pad driver sits outside the block.

Each access has two phases. The strobe is held high while the register address is shifted in. The strobe is then held low while the data byte is shifted in (for a write) or out (for a read). Both fields travel most significant bit first.

The register bank has 64 entries. Core logic reads any entry at any time through a parallel read port. The bank has no reset values, and the block reset leaves its contents as they were.

Top module: `serial_cfg_port`

## Requirements
- R1: A transfer is 8 address bits taken while `ser_strobe` is high, followed at once by 8 data bits taken while `ser_strobe` is low. Every bit is taken from `ser_din` on a rising edge of `ser_clk`, most significant bit first.
- R2: A write (`ser_rnw` low) stores the data byte in the addressed register after the eighth data bit. From then on, `core_rdata` shows the value whenever `core_raddr` selects that register.
- R3: A read (`ser_rnw` high when the eighth address bit is taken) raises `ser_oe` once the address is complete and keeps it high through the data phase. `ser_dout` presents the register value most significant bit first, and each bit changes after a falling `ser_clk` edge, so it is stable at the following rising edge.
- R4: `ser_oe` is low after reset, during the address phase, during writes and between transfers.
- R5: A write to an address from 64 to 255 changes no register. A read from such an address returns 0x00.
- R6: While `ser_csn` is high, activity on `ser_clk`, `ser_din`, `ser_strobe` and `ser_rnw` changes no register and leaves `ser_oe` low.
- R7: Raising `ser_csn` in the middle of a transfer ends it without a write. The next transfer is decoded from its first address bit.
- R8: Asserting `rst_n` does not change any register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset of the port logic |
| ser_clk | input | 1 | Serial clock, asynchronous, at most the master clock rate |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |
| ser_oe | output | 1 | High while the block drives the shared data line |
| ser_strobe | input | 1 | High for address bits, low for data bits |
| ser_rnw | input | 1 | High for a read, low for a write |
| ser_csn | input | 1 | Active-low port select |
| core_raddr | input | 6 | Register index for the parallel read port |
| core_rdata | output | 8 | Contents of the register selected by `core_raddr` |

## Verification
The hardest cases to reach are a transfer cut off by the chip select partway through, and serial clock activity while the port is deselected. In both cases the port must leave every register as it was and must start the next transfer cleanly. The bench writes a known value to a register, then raises the chip select after twelve bits, and in a second case after five bits. It also toggles the clock, strobe and data lines with the port deselected. After each of these it reads the register back serially and through the parallel port. It then runs a normal transfer to show that the bit count restarted from zero. The reset check works the same way: it writes values, pulses the reset and reads the values back.

// File: rtl/cfg_port_pkg.sv
// Shared types for the serial configuration port.
// Assumes: the user includes nothing else; the package is compiled first.
package cfg_port_pkg;
    // Transfer phase of the serial protocol engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;
endpackage

// File: rtl/cfg_sync.sv
// Two-flop synchronizer for a bundle of independent single-bit signals.
// Assumes: each bit is sampled separately; bits are not a coherent bus.
module cfg_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages bring each input into the master clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
// Configuration storage with one write port and two combinational read
// ports: one for the core logic and one for the serial engine.
// Assumes: no reset values; contents persist across the block reset.
module cfg_regfile #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [DEPTH];

    // Store the write data in the selected entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Present both read ports without added latency.
    always_comb begin
        rdata_a = mem[ridx_a];
        rdata_b = mem[ridx_b];
    end
endmodule

// File: rtl/cfg_serial_engine.sv
// Serial protocol engine: detects serial clock edges on synchronized
// inputs, shifts address and data, issues writes and shifts out read data.
// Assumes: inputs are already synchronized; each serial clock level lasts
// several master clocks; read data for addr_q is valid one cycle after
// addr_q changes.
module cfg_serial_engine
    import cfg_port_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 8,
    localparam int SW = (AW > DW) ? AW : DW,
    localparam int CW = $clog2(SW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          din_s,
    input  logic          strb_s,
    input  logic          rnw_s,
    input  logic          csn_s,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_q,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          oe,
    output logic          dout
);
    phase_t        phase;
    logic          sclk_d;
    logic          rise;
    logic          fall;
    logic [SW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          is_rd;
    logic          load_pend;
    logic [DW-1:0] tx;

    // Keep the previous serial clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Decode serial clock edges.
    always_comb begin
        rise = sclk_s & ~sclk_d;
        fall = ~sclk_s & sclk_d;
    end

    // Protocol sequencing: phases, bit counting, write issue, read shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sh        <= '0;
            cnt       <= '0;
            addr_q    <= '0;
            is_rd     <= 1'b0;
            oe        <= 1'b0;
            tx        <= '0;
            dout      <= 1'b0;
            load_pend <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_en     <= 1'b0;
            load_pend <= 1'b0;
            if (csn_s) begin
                phase <= PH_IDLE;
                cnt   <= '0;
                oe    <= 1'b0;
            end else begin
                if (load_pend) tx <= rd_word;
                if (rise) begin
                    case (phase)
                        PH_IDLE: begin
                            if (strb_s) begin
                                sh    <= {sh[SW-2:0], din_s};
                                cnt   <= CW'(1);
                                phase <= PH_ADDR;
                            end
                        end
                        PH_ADDR: begin
                            if (!strb_s) begin
                                phase <= PH_IDLE;
                                cnt   <= '0;
                            end else if (cnt == CW'(AW-1)) begin
                                addr_q    <= {sh[AW-2:0], din_s};
                                is_rd     <= rnw_s;
                                oe        <= rnw_s;
                                load_pend <= rnw_s;
                                cnt       <= '0;
                                phase     <= PH_DATA;
                            end else begin
                                sh  <= {sh[SW-2:0], din_s};
                                cnt <= cnt + CW'(1);
                            end
                        end
                        PH_DATA: begin
                            if (strb_s) begin
                                sh    <= {sh[SW-2:0], din_s};
                                cnt   <= CW'(1);
                                oe    <= 1'b0;
                                phase <= PH_ADDR;
                            end else if (cnt == CW'(DW-1)) begin
                                wr_en   <= ~is_rd;
                                wr_data <= {sh[DW-2:0], din_s};
                                oe      <= 1'b0;
                                cnt     <= '0;
                                phase   <= PH_IDLE;
                            end else begin
                                sh  <= {sh[SW-2:0], din_s};
                                cnt <= cnt + CW'(1);
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
                if (fall && phase == PH_DATA && is_rd) begin
                    dout <= tx[DW-1];
                    tx   <= {tx[DW-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/serial_cfg_port.sv
// Top level of the serial configuration port: input synchronizers,
// protocol engine, address range decode and the register bank.
// Assumes: the serial clock is no faster than the master clock; each
// serial clock level lasts at least four master clock cycles.
module serial_cfg_port #(
    parameter int  AW    = 8,
    parameter int  DW    = 8,
    parameter int  DEPTH = 64,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_oe,
    input  logic          ser_strobe,
    input  logic          ser_rnw,
    input  logic          ser_csn,
    input  logic [IW-1:0] core_raddr,
    output logic [DW-1:0] core_rdata
);
    logic          sclk_s, din_s, strb_s, rnw_s, csn_s;
    logic [AW-1:0] addr_q;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          in_range;
    logic          rf_we;
    logic [IW-1:0] rf_idx;
    logic [DW-1:0] rf_sdata;
    logic [DW-1:0] ser_word;

    cfg_sync #(.W(5), .RST_VAL(5'b00001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_din, ser_strobe, ser_rnw, ser_csn}),
        .q     ({sclk_s, din_s, strb_s, rnw_s, csn_s})
    );

    cfg_serial_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .din_s   (din_s),
        .strb_s  (strb_s),
        .rnw_s   (rnw_s),
        .csn_s   (csn_s),
        .rd_word (ser_word),
        .addr_q  (addr_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .oe      (ser_oe),
        .dout    (ser_dout)
    );

    // Decode the serial address against the implemented register range.
    always_comb begin
        in_range = addr_q < AW'(DEPTH);
        rf_idx   = addr_q[IW-1:0];
        rf_we    = wr_en & in_range;
        ser_word = in_range ? rf_sdata : '0;
    end

    cfg_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .widx    (rf_idx),
        .wdata   (wr_data),
        .ridx_a  (core_raddr),
        .rdata_a (core_rdata),
        .ridx_b  (rf_idx),
        .rdata_b (rf_sdata)
    );
endmodule

// File: rtl/cfg_port_chk.sv
// Property checker for the serial configuration port, bound to the top.
// Assumes: it observes signals only and drives nothing.
module cfg_port_chk #(
    parameter int DW = 8,
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csn_s,
    input logic          ser_oe,
    input logic          wr_en,
    input logic          rf_we,
    input logic [IW-1:0] rf_idx,
    input logic [DW-1:0] wr_data,
    input logic [IW-1:0] core_raddr,
    input logic [DW-1:0] core_rdata
);
    // R6
    csn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !ser_oe);

    // R7
    no_write_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(csn_s));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rf_we) && core_raddr == $past(rf_idx)) |-> core_rdata == $past(wr_data));

    // R3
    oe_rise_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> !$past(csn_s));
endmodule

bind serial_cfg_port cfg_port_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn_s      (csn_s),
    .ser_oe     (ser_oe),
    .wr_en      (wr_en),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .wr_data    (wr_data),
    .core_raddr (core_raddr),
    .core_rdata (core_rdata)
);

// File: tb/serial_cfg_port_test.sv
// Bench for the serial configuration port: a behavioural host driver, a
// model register array checked against the parallel read port every clock
// while the port is idle, and serial read-back checks.
module serial_cfg_port_test;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_strobe = 1'b0;
    logic       ser_rnw = 1'b0;
    logic       ser_csn = 1'b1;
    logic [5:0] core_raddr = '0;
    logic       ser_dout;
    logic       ser_oe;
    logic [7:0] core_rdata;

    int   checks = 0;
    int   errors = 0;
    bit   busy = 1'b1;
    bit   finished = 1'b0;
    logic [7:0] model_mem [64];
    bit         known [64];

    always #10 clk = ~clk;

    serial_cfg_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_dout   (ser_dout),
        .ser_oe     (ser_oe),
        .ser_strobe (ser_strobe),
        .ser_rnw    (ser_rnw),
        .ser_csn    (ser_csn),
        .core_raddr (core_raddr),
        .core_rdata (core_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-clock comparison while idle: R2 parallel read port, R4 enable low.
    always @(negedge clk) begin
        if (!busy && rst_n) begin
            if (known[core_raddr])
                check(core_rdata == model_mem[core_raddr], "R2 core read",
                      int'(core_rdata), int'(model_mem[core_raddr]));
            check(ser_oe == 1'b0, "R4 idle enable", int'(ser_oe), 0);
            core_raddr <= core_raddr + 6'd1;
        end
    end

    // One serial bit: set lines, sample read data before the rising edge.
    task automatic shift_bit(input logic strb, input logic b, output logic smp, output logic oe_s);
        ser_strobe = strb;
        ser_din    = b;
        wait_clk(HALF);
        smp  = ser_dout;
        oe_s = ser_oe;
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_clk = 1'b0;
    endtask

    // Host transfer; nbits < 16 aborts by raising chip select early.
    task automatic xfer(input logic rnw, input logic [7:0] addr, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rd);
        logic smp, oe_s;
        busy    = 1'b1;
        rd      = '0;
        ser_rnw = rnw;
        ser_csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            if (i < nbits) begin
                shift_bit(1'b1, addr[7-i], smp, oe_s);
                check(oe_s == 1'b0, "R4 address phase enable", int'(oe_s), 0);
            end
        end
        for (int i = 0; i < 8; i++) begin
            if (8 + i < nbits) begin
                shift_bit(1'b0, wd[7-i], smp, oe_s);
                rd[7-i] = smp;
                if (rnw) check(oe_s == 1'b1, "R3 read data enable", int'(oe_s), 1);
                else     check(oe_s == 1'b0, "R4 write data enable", int'(oe_s), 0);
            end
        end
        wait_clk(HALF);
        ser_csn = 1'b1;
        wait_clk(HALF);
        if (nbits >= 16 && !rnw && addr < 8'd64) begin
            model_mem[addr[5:0]] = wd;
            known[addr[5:0]]     = 1'b1;
        end
        busy = 1'b0;
        wait_clk(4);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] wd);
        logic [7:0] dummy;
        xfer(1'b0, addr, wd, 16, dummy);
    endtask

    task automatic rd_check(input logic [7:0] addr, input logic [7:0] exp, input string req);
        logic [7:0] got;
        xfer(1'b1, addr, 8'h00, 16, got);
        check(got == exp, req, int'(got), int'(exp));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            known[i]     = 1'b0;
            model_mem[i] = '0;
        end
        wait_clk(5);
        // R4: enable low while in reset and right after.
        check(ser_oe == 1'b0, "R4 reset enable", int'(ser_oe), 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(ser_oe == 1'b0, "R4 after reset enable", int'(ser_oe), 0);
        busy = 1'b0;

        // R1 R2 R3: distinct bit patterns, MSB-first in both directions.
        wr(8'h00, 8'hA5);
        wr(8'h3F, 8'h5A);
        wr(8'h15, 8'h80);
        wr(8'h2A, 8'h01);
        rd_check(8'h00, 8'hA5, "R1 read back 0x00");
        rd_check(8'h3F, 8'h5A, "R1 read back 0x3F");
        rd_check(8'h15, 8'h80, "R3 read back MSB only");
        rd_check(8'h2A, 8'h01, "R3 read back LSB only");
        for (int i = 1; i < 64; i += 9) wr(8'(i), 8'(i * 7 + 3));
        for (int i = 1; i < 64; i += 9) rd_check(8'(i), 8'(i * 7 + 3), "R2 sweep read back");

        // R5: out-of-range write leaves the aliased entry alone; read returns zero.
        wr(8'h05, 8'h33);
        wr(8'h45, 8'hEE);
        wr(8'hC5, 8'hEE);
        rd_check(8'h05, 8'h33, "R5 alias untouched");
        rd_check(8'h80, 8'h00, "R5 read 0x80 zero");
        rd_check(8'hFF, 8'h00, "R5 read 0xFF zero");

        // R7: abort in data phase and in address phase, then a clean transfer.
        wr(8'h10, 8'h77);
        begin
            logic [7:0] dummy;
            xfer(1'b0, 8'h10, 8'h11, 12, dummy);
            rd_check(8'h10, 8'h77, "R7 data-phase abort no write");
            xfer(1'b0, 8'h10, 8'h22, 5, dummy);
        end
        wr(8'h11, 8'hC3);
        rd_check(8'h11, 8'hC3, "R7 transfer after abort");
        rd_check(8'h10, 8'h77, "R7 address-phase abort no write");

        // R6: activity with chip select high is ignored.
        busy = 1'b1;
        ser_rnw = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ser_strobe = (i < 8);
            ser_din    = i[0];
            wait_clk(HALF);
            ser_clk = 1'b1;
            ser_rnw = i[1];
            wait_clk(HALF);
            ser_clk = 1'b0;
            check(ser_oe == 1'b0, "R6 deselected enable", int'(ser_oe), 0);
        end
        busy = 1'b0;
        wait_clk(4);
        rd_check(8'h10, 8'h77, "R6 deselected no write");
        wr(8'h12, 8'h96);
        rd_check(8'h12, 8'h96, "R6 transfer after deselected activity");

        // R8: reset pulse keeps contents.
        busy  = 1'b1;
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        busy = 1'b0;
        rd_check(8'h00, 8'hA5, "R8 contents after reset 0x00");
        rd_check(8'h3F, 8'h5A, "R8 contents after reset 0x3F");
        rd_check(8'h12, 8'h96, "R8 contents after reset 0x12");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x%0h expected=0x%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule